// File: doc/BRIEF.md
# Packed 52-bit Multiply-Accumulate Unit

This block is a pipelined SIMD datapath. It splits a wide vector into independent 64-bit lanes. In every lane it forms the full unsigned product of the low 52 bits of two multiplicand lanes, which is 104 bits wide. It then keeps either the upper or the lower 52-bit half of that product. The kept half is widened with zeros and added to a 64-bit accumulator lane.

An operation enters with `in_valid`. Each operation carries its own half select, `in_hi`. The block accepts a new operation on every clock, so a stream of operations can mix both halves freely. Results come out in issue order, exactly three cycles after they entered. This suits wide-integer arithmetic such as modular multiplication. There, limbs of 52 bits are multiplied, and the low and high halves of each product are folded into separate 64-bit accumulators.

Top module: `pmac52_unit`

## Requirements
- R1: The vector splits into VEC_W/64 lanes. Lane k occupies bits [64k+63:64k] of every vector port. Each lane's result depends only on the same lane of the inputs.
- R2: Only bits 51:0 of each lane of `in_b` and `in_c` enter the multiply, read as unsigned. Bits 63:52 of those lanes have no effect on the result.
- R3: When `in_hi` is 1, the lane adds bits 103:52 of the 104-bit product to the accumulator lane.
- R4: When `in_hi` is 0, the lane adds bits 51:0 of the 104-bit product to the accumulator lane.
- R5: The accumulator addition is unsigned and wraps modulo 2^64. No carry is reported.
- R6: `out_valid` in cycle t+3 equals `in_valid` in cycle t, and `out_res` in that cycle holds the result for the inputs of cycle t. A new operation may enter on every cycle.
- R7: The half select is captured with its operands, so consecutive operations may use different halves.
- R8: A synchronous active-high `rst` clears every pipeline valid bit. While `rst` is high, and during the first three cycles after it is released, `out_valid` is 0.
- R9: With accumulator 10·2^40, B = 11·2^40+4 and C = 12·2^40+3, a lane gives 11030549757952 when `in_hi` is 1 and 100055558127628 when `in_hi` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers use its rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | An operation is presented this cycle |
| in_hi | input | 1 | 1 selects the upper product half, 0 selects the lower |
| in_acc | input | VEC_W | Accumulator lanes, 64 bits each |
| in_b | input | VEC_W | First multiplicand lanes; low 52 bits used |
| in_c | input | VEC_W | Second multiplicand lanes; low 52 bits used |
| out_valid | output | 1 | `out_res` holds a result this cycle |
| out_res | output | VEC_W | Result lanes |

## Verification
A corrupted valid bit inside the pipeline makes `out_valid` lose or invent a result. That error shows up exactly three cycles after the operation it belongs to. A wrong half select, a lost operand bit or a broken lane carry shows up in a single 64-bit lane of `out_res`, in the same three-cycle slot. Because the bench keeps a reference for every cycle, such an error is caught at its first occurrence. An error in one lane cannot be hidden by the other lanes, since each lane is compared on its own.

// File: rtl/pmac52_pkg.sv
package pmac52_pkg;
   localparam int LANE_W   = 64;
   localparam int MUL_W    = 52;
   localparam int PIPE_LAT = 3;

   typedef enum logic {
      HALF_LO = 1'b0,
      HALF_HI = 1'b1
   } half_e;
endpackage

// File: rtl/pmac52_vpipe.sv
module pmac52_vpipe
   import pmac52_pkg::*;
#(
   parameter int DEPTH = PIPE_LAT
) (
   input  logic clk,
   input  logic rst,
   input  logic in_valid,
   output logic out_valid
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [DEPTH-1:0] vld_q;
   logic [CNT_W-1:0] run_cnt;

   always_ff @(posedge clk) begin
      if (rst) vld_q[0] <= 1'b0;
      else     vld_q[0] <= in_valid;
   end

   for (genvar s = 1; s < DEPTH; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) vld_q[s] <= 1'b0;
         else     vld_q[s] <= vld_q[s-1];
      end
   end

   assign out_valid = vld_q[DEPTH-1];

   // cycles since reset release, saturating at DEPTH (used by the checks)
   always_ff @(posedge clk) begin
      if (rst)                      run_cnt <= '0;
      else if (run_cnt != CNT_W'(DEPTH)) run_cnt <= run_cnt + 1'b1;
   end

   // R6
   valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
      (run_cnt == CNT_W'(DEPTH)) |-> (out_valid == $past(in_valid, 3)));

   // R8
   reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (run_cnt != CNT_W'(DEPTH)) |-> !out_valid);
endmodule

// File: rtl/pmac52_lane.sv
module pmac52_lane
   import pmac52_pkg::*;
#(
   parameter int LW = LANE_W,
   parameter int MW = MUL_W
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_hi,
   input  logic [LW-1:0] acc,
   input  logic [LW-1:0] opb,
   input  logic [LW-1:0] opc,
   output logic [LW-1:0] sum
);
   localparam int PW  = 2 * MW;
   localparam int PAD = LW - MW;

   // stage 1: operand capture, upper lane bits dropped here
   logic [MW-1:0] s1_b, s1_c;
   logic [LW-1:0] s1_acc;
   half_e         s1_half;

   // stage 2: full product
   logic [PW-1:0] s2_prod;
   logic [LW-1:0] s2_acc;
   half_e         s2_half;

   logic [MW-1:0] addend;

   always_ff @(posedge clk) begin
      s1_b    <= opb[MW-1:0];
      s1_c    <= opc[MW-1:0];
      s1_acc  <= acc;
      s1_half <= in_hi ? HALF_HI : HALF_LO;
   end

   always_ff @(posedge clk) begin
      s2_prod <= PW'(s1_b) * PW'(s1_c);
      s2_acc  <= s1_acc;
      s2_half <= s1_half;
   end

   always_comb begin
      if (s2_half == HALF_HI) addend = s2_prod[PW-1:MW];
      else                    addend = s2_prod[MW-1:0];
   end

   always_ff @(posedge clk) begin
      sum <= s2_acc + {{PAD{1'b0}}, addend};
   end

   // R2
   zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
      ((s1_b == '0) || (s1_c == '0)) |=> (s2_prod == '0));

   // R5
   addend_range_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (((sum - $past(s2_acc)) >> MW) == '0));

   // R3
   hi_small_product_chk: assert property (@(posedge clk) disable iff (rst)
      ((s2_half == HALF_HI) && (s2_prod[PW-1:MW] == '0)) |=> (sum == $past(s2_acc)));
endmodule

// File: rtl/pmac52_unit.sv
module pmac52_unit
   import pmac52_pkg::*;
#(
   parameter int VEC_W = 512,
   parameter int LW    = LANE_W,
   parameter int MW    = MUL_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic             in_hi,
   input  logic [VEC_W-1:0] in_acc,
   input  logic [VEC_W-1:0] in_b,
   input  logic [VEC_W-1:0] in_c,
   output logic             out_valid,
   output logic [VEC_W-1:0] out_res
);
   localparam int LANES = VEC_W / LW;

   if (VEC_W != 128 && VEC_W != 256 && VEC_W != 512)
      $error("pmac52_unit: VEC_W must be 128, 256 or 512");
   if (VEC_W % LW != 0)
      $error("pmac52_unit: VEC_W must be a multiple of the lane width");
   if (MW >= LW || MW < 1)
      $error("pmac52_unit: multiply width must be below the lane width");

   pmac52_vpipe #(.DEPTH(PIPE_LAT)) u_vpipe (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .out_valid (out_valid)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      pmac52_lane #(.LW(LW), .MW(MW)) u_lane (
         .clk   (clk),
         .rst   (rst),
         .in_hi (in_hi),
         .acc   (in_acc[k*LW +: LW]),
         .opb   (in_b[k*LW +: LW]),
         .opc   (in_c[k*LW +: LW]),
         .sum   (out_res[k*LW +: LW])
      );
   end
endmodule

// File: tb/sim_pmac52_unit.sv
module sim_pmac52_unit;
   localparam int VW    = 512;
   localparam int NL    = VW / 64;
   localparam int LIMIT = 200000;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic          in_hi = 1'b0;
   logic [VW-1:0] in_acc = '0, in_b = '0, in_c = '0;
   logic          out_valid;
   logic [VW-1:0] out_res;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   bit            q_v[$];
   logic [VW-1:0] q_r[$];
   string         q_t[$];

   always #4 clk = ~clk;

   pmac52_unit #(.VEC_W(VW)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_hi(in_hi),
      .in_acc(in_acc), .in_b(in_b), .in_c(in_c),
      .out_valid(out_valid), .out_res(out_res)
   );

   function automatic logic [63:0] lane_ref(logic [63:0] a, logic [63:0] b,
                                            logic [63:0] c, bit hi);
      logic [127:0] p;
      logic [63:0]  h;
      p = {76'd0, b[51:0]} * {76'd0, c[51:0]};
      h = hi ? {12'd0, p[103:52]} : {12'd0, p[51:0]};
      return a + h;
   endfunction

   function automatic logic [63:0] rnd64();
      return {$urandom(), $urandom()};
   endfunction

   task automatic step(input bit r, input bit v, input bit h,
                       input logic [VW-1:0] a, input logic [VW-1:0] b,
                       input logic [VW-1:0] c, input string tag,
                       input bit use_ovr, input logic [VW-1:0] ovr);
      bit            ev;
      logic [VW-1:0] er, ex;
      string         et;
      @(negedge clk);
      if (q_v.size() == 3) begin
         ev = q_v.pop_front();
         er = q_r.pop_front();
         et = q_t.pop_front();
         checks++;
         if (out_valid !== ev) begin
            failures++;
            $display("FAIL R6 out_valid actual=%0b expected=%0b", out_valid, ev);
         end
         if (ev) begin
            for (int k = 0; k < NL; k++) begin
               checks++;
               if (out_res[k*64 +: 64] !== er[k*64 +: 64]) begin
                  failures++;
                  $display("FAIL %s lane %0d actual=%0d expected=%0d", et, k,
                           out_res[k*64 +: 64], er[k*64 +: 64]);
               end
            end
         end
      end else begin
         checks++;
         if (out_valid !== 1'b0) begin
            failures++;
            $display("FAIL R8 out_valid actual=%0b expected=0", out_valid);
         end
      end
      rst = r; in_valid = v; in_hi = h; in_acc = a; in_b = b; in_c = c;
      for (int k = 0; k < NL; k++)
         ex[k*64 +: 64] = lane_ref(a[k*64 +: 64], b[k*64 +: 64], c[k*64 +: 64], h);
      if (use_ovr) ex = ovr;
      if (r) begin
         q_v.delete(); q_r.delete(); q_t.delete();
      end else begin
         q_v.push_back(v);
         q_r.push_back(ex);
         q_t.push_back(v ? tag : "R6");
      end
   endtask

   task automatic op(input bit h, input logic [VW-1:0] a, input logic [VW-1:0] b,
                     input logic [VW-1:0] c, input string tag);
      step(1'b0, 1'b1, h, a, b, c, tag, 1'b0, '0);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, '0, '0, '0, "R6", 1'b0, '0);
   endtask

   initial begin
      logic [VW-1:0] a, b, c, e;
      // R8: reset state
      for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, '0, '0, '0, "R8", 1'b0, '0);
      idle(3);
      // R9: worked vector in both modes
      a = {NL{64'd10 << 40}};
      b = {NL{(64'd11 << 40) + 64'd4}};
      c = {NL{(64'd12 << 40) + 64'd3}};
      e = {NL{64'd11030549757952}};
      step(1'b0, 1'b1, 1'b1, a, b, c, "R9", 1'b1, e);
      e = {NL{64'd100055558127628}};
      step(1'b0, 1'b1, 1'b0, a, b, c, "R9", 1'b1, e);
      // R2: all-ones fields and junk above bit 51
      b = {NL{64'hFFFF_FFFF_FFFF_FFFF}};
      c = {NL{64'hABC0_0000_0000_0007}};
      op(1'b1, '0, b, b, "R2");
      op(1'b0, '0, b, b, "R2");
      op(1'b0, {NL{64'd5}}, b, c, "R2");
      op(1'b1, {NL{64'd5}}, c, b, "R2");
      // R5: accumulator wrap
      a = {NL{64'hFFFF_FFFF_FFFF_FFF0}};
      op(1'b0, a, {NL{64'd3}}, {NL{64'd7}}, "R5");
      op(1'b1, a, b, b, "R5");
      // R1: each lane distinct
      for (int k = 0; k < NL; k++) begin
         a[k*64 +: 64] = 64'd1000 * (k + 1);
         b[k*64 +: 64] = 64'd3 + k;
         c[k*64 +: 64] = (64'd1 << (40 + k)) + k;
      end
      op(1'b0, a, b, c, "R1");
      op(1'b1, a, b, c, "R1");
      idle(2);
      // R7: alternating modes back to back
      for (int i = 0; i < 16; i++) begin
         for (int k = 0; k < NL; k++) begin
            a[k*64 +: 64] = rnd64(); b[k*64 +: 64] = rnd64(); c[k*64 +: 64] = rnd64();
         end
         op(i[0], a, b, c, "R7");
      end
      // R8: reset with the pipeline full, then restart
      op(1'b1, a, b, c, "R7");
      step(1'b1, 1'b1, 1'b1, a, b, c, "R8", 1'b0, '0);
      step(1'b1, 1'b0, 1'b0, a, b, c, "R8", 1'b0, '0);
      idle(1);
      // R3 / R4 / R6: random stream with gaps
      for (int i = 0; i < 300; i++) begin
         for (int k = 0; k < NL; k++) begin
            a[k*64 +: 64] = rnd64(); b[k*64 +: 64] = rnd64(); c[k*64 +: 64] = rnd64();
         end
         if (($urandom() % 4) == 0) idle(1);
         else begin
            if (($urandom() % 2) == 0) op(1'b1, a, b, c, "R3");
            else                       op(1'b0, a, b, c, "R4");
         end
      end
      idle(4);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (LIMIT) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule